// File: doc/BRIEF.md
# Three-Wire Serial Register Access Slave

This block lets an external host read and write a bank of byte-wide internal registers over a serial link with four lines. The lines are an active-low chip select, a serial clock, a data input and a data output. The host pulls chip select low and clocks in a command byte. The command byte gives the transfer direction and the first register to touch. Data bytes follow in the chosen direction, and the register pointer moves forward by one after every byte. Past the last register the pointer returns to register zero.

The serial lines are brought into the block's own clock domain through synchronizers. Clock edges are then detected as single-cycle events. While chip select is high, the shift logic, the command decoder and the output driver are all held idle. The data output carries an enable. The enable is asserted only while read data is being returned, so the input and output may share one bidirectional wire.

Top module: `spi3_regslave`

## Requirements
- R1: While cs_n is high, the serial interface is held idle: sclk and sdi have no effect, sdo_oe is low, and a transfer cut short by cs_n rising leaves the registers unchanged and restarts with a fresh command byte.
- R2: Every byte on sdi and sdo is sent most significant bit first. sdi is sampled on the rising edge of sclk.
- R3: The first byte after cs_n falls is a command. Bit 7 is the direction (1 = read, 0 = write) and bits 6:0 are the starting register address.
- R4: sdo changes only after a falling sclk edge (or when cs_n rises). On a read, the current register is loaded for output on the falling edge that ends the command byte, and again on the falling edge that ends each data byte.
- R5: The register pointer advances by one after each data byte. After register NREG-1 it returns to 0 (default NREG = 28).
- R6: A starting address of NREG or above is treated as address 0.
- R7: A write updates a register only when all 8 bits of a data byte have arrived. A partial byte is discarded.
- R8: sdo_oe is high only in the data phase of a read. While sdo_oe is low, sdo is 0.
- R9: After reset every register holds 0, and sdo_oe and sdo are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, used to sample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Drive enable for sdo |

## Verification
A serial edge reaches the logic after the synchronizer stages, two clk cycles by default. The resulting sdo or sdo_oe change is registered one cycle later, so the output settles within three clk cycles of an sclk or cs_n transition. The bench holds each sclk half period for six clk cycles and reads sdo at the end of the low half, just before the rising edge. A written register is checked only by a later read transfer. Before starting that read, the bench waits two half periods after cs_n rises, which also covers the drop of sdo_oe.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
  localparam int DW      = 8;
  localparam int AW      = 7;
  localparam int RW_BIT  = 7;
  localparam int CNTW    = $clog2(DW);

  typedef enum logic [0:0] {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
      else        chain_q <= {chain_q[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi3_rx.sv
module spi3_rx
  import spi3_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            shift_en,
  input  logic            din,
  output logic [DW-1:0]   byte_o,
  output logic            byte_done,
  output logic [CNTW-1:0] bit_cnt
);
  logic [DW-2:0]   sh_q, sh_n;
  logic [CNTW-1:0] cnt_q, cnt_n;

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    if (clr) begin
      cnt_n = '0;
    end else if (shift_en) begin
      cnt_n = cnt_q + 1'b1;
      sh_n  = {sh_q[DW-3:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
    end
  end

  assign byte_o    = {sh_q, din};
  assign byte_done = shift_en && !clr && (cnt_q == CNTW'(DW - 1));
  assign bit_cnt   = cnt_q;
endmodule

// File: rtl/spi3_tx.sv
module spi3_tx
  import spi3_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic          shift,
  input  logic [DW-1:0] din,
  output logic          dout,
  output logic          oe
);
  logic [DW-1:0] sh_q, sh_n;
  logic          oe_q, oe_n;

  always_comb begin
    sh_n = sh_q;
    oe_n = oe_q;
    if (clr) begin
      sh_n = '0;
      oe_n = 1'b0;
    end else if (load) begin
      sh_n = din;
      oe_n = 1'b1;
    end else if (shift) begin
      sh_n = {sh_q[DW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else begin
      sh_q <= sh_n;
      oe_q <= oe_n;
    end
  end

  assign dout = oe_q & sh_q[DW-1];
  assign oe   = oe_q;
endmodule

// File: rtl/spi3_regbank.sv
module spi3_regbank
  import spi3_pkg::*;
#(
  parameter int NREG = 28,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++)
        if (wr_addr == IW'(i)) mem_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == IW'(i)) rd_data = mem_q[i];
  end
endmodule

// File: rtl/spi3_regslave.sv
module spi3_regslave
  import spi3_pkg::*;
#(
  parameter int NREG        = 28,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic cs_s, sclk_s, sdi_s, sclk_d_q;
  spi3_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   ({cs_n, sclk, sdi}),
    .dout  ({cs_s, sclk_s, sdi_s})
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) sclk_d_q <= 1'b0;
    else            sclk_d_q <= sclk_s;
  end

  logic cs_act, sclk_rise, sclk_fall, clr;
  assign cs_act    = ~cs_s;
  assign clr       = ~cs_act;
  assign sclk_rise = cs_act &  sclk_s & ~sclk_d_q;
  assign sclk_fall = cs_act & ~sclk_s &  sclk_d_q;

  logic [DW-1:0]   rx_byte;
  logic            rx_done;
  logic [CNTW-1:0] rx_cnt;
  spi3_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (clr),
    .shift_en  (sclk_rise),
    .din       (sdi_s),
    .byte_o    (rx_byte),
    .byte_done (rx_done),
    .bit_cnt   (rx_cnt)
  );

  phase_e        phase_q, phase_n;
  logic          rd_q, rd_n;
  logic          pend_q, pend_n;
  logic [IW-1:0] addr_q, addr_n, addr_inc;
  logic          wr_en, tx_load, tx_shift;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] cmd_addr;
  logic          rd_mode;

  assign addr_inc = (addr_q == IW'(NREG - 1)) ? '0 : addr_q + 1'b1;
  assign cmd_addr = rx_byte[AW-1:0];
  assign rd_mode  = (phase_q == PH_DATA) && rd_q;

  always_comb begin
    phase_n  = phase_q;
    rd_n     = rd_q;
    pend_n   = pend_q;
    addr_n   = addr_q;
    wr_en    = 1'b0;
    tx_load  = 1'b0;
    tx_shift = 1'b0;
    if (clr) begin
      phase_n = PH_CMD;
      rd_n    = 1'b0;
      pend_n  = 1'b0;
      addr_n  = '0;
    end else begin
      if (rx_done) begin
        if (phase_q == PH_CMD) begin
          phase_n = PH_DATA;
          rd_n    = rx_byte[RW_BIT];
          pend_n  = rx_byte[RW_BIT];
          addr_n  = (32'(cmd_addr) < NREG) ? IW'(cmd_addr) : '0;
        end else if (!rd_q) begin
          wr_en  = 1'b1;
          addr_n = addr_inc;
        end else begin
          pend_n = 1'b1;
        end
      end
      if (sclk_fall && rd_mode) begin
        if (pend_q) begin
          tx_load = 1'b1;
          pend_n  = 1'b0;
          addr_n  = addr_inc;
        end else begin
          tx_shift = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q <= PH_CMD;
      rd_q    <= 1'b0;
      pend_q  <= 1'b0;
      addr_q  <= '0;
    end else begin
      phase_q <= phase_n;
      rd_q    <= rd_n;
      pend_q  <= pend_n;
      addr_q  <= addr_n;
    end
  end

  spi3_regbank #(.NREG(NREG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (addr_q),
    .wr_data (rx_byte),
    .rd_addr (addr_q),
    .rd_data (rd_data)
  );

  spi3_tx u_tx (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (clr),
    .load  (tx_load),
    .shift (tx_shift),
    .din   (rd_data),
    .dout  (sdo),
    .oe    (sdo_oe)
  );
endmodule

// File: rtl/spi3_regslave_chk.sv
module spi3_regslave_chk #(
  parameter int NREG = 28,
  parameter int IW   = 5,
  parameter int CW   = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_act,
  input logic          sclk_fall,
  input logic          rd_mode,
  input logic [IW-1:0] addr,
  input logic [CW-1:0] bit_cnt,
  input logic          sdo,
  input logic          sdo_oe
);
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdo_oe);                                        // R1
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == '0));                                // R1
  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> ($past(sclk_fall) || !$past(cs_act)));     // R4
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(addr) < NREG);                                           // R5
  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);                                           // R8
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> rd_mode);                                         // R8
endmodule

bind spi3_regslave spi3_regslave_chk #(
  .NREG (NREG),
  .IW   (IW),
  .CW   (spi3_pkg::CNTW)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .cs_act    (cs_act),
  .sclk_fall (sclk_fall),
  .rd_mode   (rd_mode),
  .addr      (addr_q),
  .bit_cnt   (rx_cnt),
  .sdo       (sdo),
  .sdo_oe    (sdo_oe)
);

// File: tb/spi3_regslave_tb.sv
module spi3_regslave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int NREG       = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdo_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi3_regslave #(.NREG(NREG)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  function automatic logic [7:0] pat(int i, int salt);
    return 8'((i * 37 + 5 + salt * 11) & 255);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] mosi, input int nbits,
                      output logic [7:0] miso, output logic oe_any,
                      output logic oe_all);
    miso = '0; oe_any = 1'b0; oe_all = 1'b1;
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi = mosi[i];
      wait_clk(HALF);
      miso[i] = sdo;
      oe_any |= sdo_oe;
      oe_all &= sdo_oe;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic frame_open();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic frame_close();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  function automatic int start_of(int a);
    return (a < NREG) ? a : 0;
  endfunction

  task automatic do_write(int a, int n, int salt, string tag);
    logic [7:0] r; logic any, all;
    logic oe_seen = 1'b0;
    int p = start_of(a);
    frame_open();
    xfer({1'b0, 7'(a)}, 8, r, any, all);
    oe_seen |= any;
    for (int k = 0; k < n; k++) begin
      xfer(pat(k, salt), 8, r, any, all);
      oe_seen |= any;
      model[p] = pat(k, salt);
      p = (p == NREG - 1) ? 0 : p + 1;
    end
    frame_close();
    chk({tag, " R8 oe during write"}, 8'(oe_seen), 8'd0);
  endtask

  task automatic do_read(int a, int n, string tag);
    logic [7:0] r; logic any, all;
    int p = start_of(a);
    frame_open();
    xfer({1'b1, 7'(a)}, 8, r, any, all);
    chk({tag, " R8 oe low in command"}, 8'(any), 8'd0);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, r, any, all);
      chk($sformatf("%s R2 R4 R5 read addr %0d", tag, p), r, model[p]);
      if (k == 0) chk({tag, " R8 oe high in read data"}, 8'(all), 8'd1);
      p = (p == NREG - 1) ? 0 : p + 1;
    end
    frame_close();
    chk({tag, " R1 oe low after cs_n high"}, {6'd0, sdo_oe, sdo}, 8'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r; logic any, all;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(6);
    // R9 reset state
    chk("R9 reset sdo_oe/sdo", {6'd0, sdo_oe, sdo}, 8'd0);
    do_read(0, NREG, "R9 reset contents");
    // R3 write burst over the whole bank, then read with wrap
    do_write(0, NREG, 0, "R3 full write");
    do_read(0, NREG + 2, "R5 full read wrap");
    // R5 write across the wrap point
    do_write(NREG - 1, 2, 3, "R5 wrap write");
    do_read(NREG - 1, 3, "R5 wrap read");
    // R6 out-of-range start addresses
    do_read(100, 2, "R6 read start 100");
    do_write(127, 1, 7, "R6 write start 127");
    do_read(0, 1, "R6 check reg0");
    do_read(NREG, 1, "R6 read start NREG");
    // R7 partial byte discarded
    frame_open();
    xfer({1'b0, 7'd5}, 8, r, any, all);
    xfer(8'hFF, 4, r, any, all);
    frame_close();
    do_read(5, 1, "R7 partial write");
    // R1 sclk/sdi ignored while cs_n high
    for (int k = 0; k < 16; k++) begin
      sdi = k[0];
      sclk = 1'b1; wait_clk(HALF);
      chk("R1 oe idle while toggling", {6'd0, sdo_oe, sdo}, 8'd0);
      sclk = 1'b0; wait_clk(HALF);
    end
    // R1 command cut short restarts cleanly
    frame_open();
    xfer(8'h03, 3, r, any, all);
    frame_close();
    do_read(3, 2, "R1 restart after abort");
    // sweep: single-byte write and read of every address
    for (int a = 0; a < NREG; a++) begin
      do_write(a, 1, a + 20, "R3 sweep write");
      do_read(a, 1, "R4 sweep read");
    end
    do_read(0, NREG, "R5 final bank");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule